// File: doc/BRIEF.md
# Runahead Checkpoint Controller

This block lets an out-of-order core keep working while its oldest in-flight instruction, a load, waits on a cache miss. When that load reaches the head of the reorder window and is known to have missed, the controller takes a checkpoint. The checkpoint holds the committed register values, the rename map, the return-address-stack pointer and the branch history. The controller then switches the core into a throwaway speculative mode. In that mode the missing load's destination register is marked poisoned. The poison spreads to every result that depends on it. Memory traffic from this mode serves only as prefetch. Stores never reach the data cache: they land in a small private cache that later loads in the same mode can read.

When the data for the original miss arrives, the controller spends exactly one cycle in a restore mode. During that cycle it flushes the pipeline, presents the saved rename map, stack pointer, branch history and the restart program counter, and stalls the memory request stream. On the edge that ends the cycle it reloads the working register file from the checkpoint and empties the private cache. The core is then back in normal mode with its state exactly as it was when the miss was found.

The memory request path is valid/ready. A request counts as accepted in a cycle where `mreq_valid` and `mreq_ready` are both high. In normal mode, requests pass straight to the data-cache port and that port's `dc_ready` is returned upstream as back-pressure. In runahead mode the controller absorbs stores, poisoned requests and hits in the private cache itself, with ready held high. Only clean loads that miss the private cache go out as prefetches, and those wait on `dc_ready`. In restore mode `mreq_ready` is low and nothing is issued.

Top module: `ra_controller`

## Requirements
- R1: After reset, `mode_o` is 0 (normal), `flush` and `restore_valid` are low, every working register reads 0 and no register is poisoned.
- R2: The mode changes from normal (0) to runahead (1) on a clock edge only when `head_valid`, `head_is_load` and `head_miss` are all high in that cycle; otherwise it stays normal.
- R3: On entry, the destination `head_dst` of the missing load reads poisoned. The rename map, stack pointer and branch history sampled on the entry edge appear on `restore_rmap`, `restore_ras_ptr` and `restore_bhr` during restore.
- R4: A further head miss during runahead neither moves the checkpoint nor changes the awaited miss identifier or the restart address.
- R5: A `fill_valid` whose `fill_id` equals the missing load's `head_id` moves runahead to restore (2). Restore lasts exactly one cycle, with `flush` and `restore_valid` high and `restart_pc` equal to the missing load's `head_pc`. Fills with another identifier are ignored.
- R6: After restore, every working register is bit-identical to the committed value at entry, including a write made in the entry cycle, and none is poisoned.
- R7: A write during runahead stores `wb_poison` with the data. `op_poison` is the OR of the poison bits of `opa_idx` and `opb_idx`. A write in normal mode clears the poison bit.
- R8: During runahead no store reaches the data-cache port (`dc_valid` with `dc_store` never both high). A clean store fills a private cache entry indexed by address bits [3:2] and tagged with the full address. A clean load that hits it is answered through `rc_hit`/`rc_data` with no data-cache request. The private cache is empty after restore.
- R9: During runahead a poisoned request is accepted (`mreq_ready` high) and dropped (`dc_valid` low), and a poisoned branch gets `br_redirect_ok` low. A clean branch gets it high.
- R10: In normal mode `dc_valid` follows `mreq_valid` and `mreq_ready` follows `dc_ready`. In runahead a clean load that misses the private cache goes out as a load prefetch under the same handshake. In restore `mreq_ready` and `dc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_valid | input | 1 | Oldest window entry is valid |
| head_is_load | input | 1 | Oldest entry is a load |
| head_miss | input | 1 | Oldest entry missed in the cache |
| head_id | input | IDW | Miss identifier of the oldest entry |
| head_pc | input | PCW | Program counter of the oldest entry |
| head_dst | input | log2(NREG) | Destination register of the oldest entry |
| fill_valid | input | 1 | A miss has returned data |
| fill_id | input | IDW | Identifier of the returned miss |
| live_rmap | input | NREG*PTW | Current rename map, flattened |
| live_ras_ptr | input | RASW | Current return-stack pointer |
| live_bhr | input | BHRW | Current branch history |
| wb_en | input | 1 | Register write enable |
| wb_idx | input | log2(NREG) | Register write index |
| wb_data | input | DW | Register write data |
| wb_poison | input | 1 | Written result depends on a bogus value |
| rd_idx | input | log2(NREG) | Register read index |
| rd_data | output | DW | Register read data |
| rd_poison | output | 1 | Poison bit of the read register |
| opa_idx | input | log2(NREG) | First source operand index |
| opb_idx | input | log2(NREG) | Second source operand index |
| op_poison | output | 1 | Either source is poisoned |
| mreq_valid | input | 1 | Memory request valid |
| mreq_ready | output | 1 | Memory request accepted |
| mreq_store | input | 1 | Request is a store |
| mreq_poison | input | 1 | Request address or data is poisoned |
| mreq_addr | input | AW | Request address |
| mreq_wdata | input | DW | Store data |
| dc_valid | output | 1 | Data-cache request valid |
| dc_ready | input | 1 | Data cache accepts the request |
| dc_store | output | 1 | Data-cache request is a store |
| dc_addr | output | AW | Data-cache request address |
| dc_wdata | output | DW | Data-cache store data |
| rc_hit | output | 1 | Runahead load answered by the private cache |
| rc_data | output | DW | Data from the private cache |
| br_valid | input | 1 | A branch resolves this cycle |
| br_poison | input | 1 | The branch condition is poisoned |
| br_redirect_ok | output | 1 | The branch may redirect fetch |
| mode_o | output | 2 | 0 normal, 1 runahead, 2 restore |
| flush | output | 1 | Flush the pipeline |
| restore_valid | output | 1 | Saved state on the restore outputs is to be loaded |
| restore_rmap | output | NREG*PTW | Saved rename map |
| restore_ras_ptr | output | RASW | Saved return-stack pointer |
| restore_bhr | output | BHRW | Saved branch history |
| restart_pc | output | PCW | Address at which fetch restarts |

## Verification
The assertions check the mode sequence on every cycle: normal only leaves on a head miss, restore only follows runahead and lasts one cycle, and the checkpoint outputs stay frozen through runahead. On every cycle they also check that no store reaches the data cache outside normal mode, that restore holds off the request stream, and that poisoned branches never redirect. Only the bench's scenarios can show that the register file after exit matches the committed values bit for bit. The same holds for poison propagating correctly through random write sequences, and for the private cache forwarding stored data and emptying at exit, because each of these depends on a history of writes that the bench models.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef enum logic [1:0] {
    M_NORMAL   = 2'd0,
    M_RUNAHEAD = 2'd1,
    M_RESTORE  = 2'd2
  } ra_mode_e;
endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
  import ra_pkg::*;
#(
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           head_valid,
  input  logic           head_is_load,
  input  logic           head_miss,
  input  logic [IDW-1:0] head_id,
  input  logic           fill_valid,
  input  logic [IDW-1:0] fill_id,
  output ra_mode_e       mode,
  output logic           enter,
  output logic           do_restore
);
  logic [IDW-1:0] wait_id;
  ra_mode_e       mode_nx;
  logic           fill_hit;

  assign enter      = (mode == M_NORMAL) && head_valid && head_is_load && head_miss;
  assign fill_hit   = (mode == M_RUNAHEAD) && fill_valid && (fill_id == wait_id);
  assign do_restore = (mode == M_RESTORE);

  always_comb begin
    mode_nx = mode;
    unique case (mode)
      M_NORMAL:   if (enter) mode_nx = M_RUNAHEAD;
      M_RUNAHEAD: if (fill_hit) mode_nx = M_RESTORE;
      M_RESTORE:  mode_nx = M_NORMAL;
      default:    mode_nx = M_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_NORMAL;
      wait_id <= '0;
    end else begin
      mode <= mode_nx;
      if (enter) wait_id <= head_id;
    end
  end
endmodule

// File: rtl/ra_ckpt_store.sv
module ra_ckpt_store
  import ra_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int PTW  = 6,
  parameter int RASW = 4,
  parameter int BHRW = 12,
  parameter int PCW  = 32,
  localparam int RIW = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ra_mode_e            mode,
  input  logic                enter,
  input  logic                wb_en,
  input  logic [RIW-1:0]      wb_idx,
  input  logic [DW-1:0]       wb_data,
  input  logic [NREG*PTW-1:0] live_rmap,
  input  logic [RASW-1:0]     live_ras_ptr,
  input  logic [BHRW-1:0]     live_bhr,
  input  logic [PCW-1:0]      head_pc,
  output logic [NREG*DW-1:0]  ck_data,
  output logic [NREG*PTW-1:0] ck_rmap,
  output logic [RASW-1:0]     ck_ras_ptr,
  output logic [BHRW-1:0]     ck_bhr,
  output logic [PCW-1:0]      ck_pc
);
  // Committed shadow: follows every normal-mode write, frozen otherwise.
  for (genvar g = 0; g < NREG; g++) begin : g_shadow
    logic [DW-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else if (wb_en && (mode == M_NORMAL) && (wb_idx == RIW'(g))) sh <= wb_data;
    end
    assign ck_data[g*DW +: DW] = sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_rmap    <= '0;
      ck_ras_ptr <= '0;
      ck_bhr     <= '0;
      ck_pc      <= '0;
    end else if (enter) begin
      ck_rmap    <= live_rmap;
      ck_ras_ptr <= live_ras_ptr;
      ck_bhr     <= live_bhr;
      ck_pc      <= head_pc;
    end
  end
endmodule

// File: rtl/ra_regfile.sv
module ra_regfile
  import ra_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int RIW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ra_mode_e           mode,
  input  logic               enter,
  input  logic [RIW-1:0]     enter_dst,
  input  logic               wb_en,
  input  logic [RIW-1:0]     wb_idx,
  input  logic [DW-1:0]      wb_data,
  input  logic               wb_poison,
  input  logic               do_restore,
  input  logic [NREG*DW-1:0] ck_data,
  input  logic [RIW-1:0]     rd_idx,
  output logic [DW-1:0]      rd_data,
  output logic               rd_poison,
  input  logic [RIW-1:0]     opa_idx,
  input  logic [RIW-1:0]     opb_idx,
  output logic               op_poison
);
  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] psn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      psn <= '0;
    end else if (do_restore) begin
      for (int i = 0; i < NREG; i++) mem[i] <= ck_data[i*DW +: DW];
      psn <= '0;
    end else begin
      if (wb_en && (mode != M_RESTORE)) begin
        mem[wb_idx] <= wb_data;
        psn[wb_idx] <= (mode == M_RUNAHEAD) && wb_poison;
      end
      if (enter) psn[enter_dst] <= 1'b1;
    end
  end

  assign rd_data   = mem[rd_idx];
  assign rd_poison = psn[rd_idx];
  assign op_poison = psn[opa_idx] | psn[opb_idx];
endmodule

// File: rtl/ra_mem_gate.sv
module ra_mem_gate
  import ra_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RCN = 4,
  localparam int IW = $clog2(RCN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ra_mode_e      mode,
  input  logic          do_restore,
  input  logic          mreq_valid,
  output logic          mreq_ready,
  input  logic          mreq_store,
  input  logic          mreq_poison,
  input  logic [AW-1:0] mreq_addr,
  input  logic [DW-1:0] mreq_wdata,
  output logic          dc_valid,
  input  logic          dc_ready,
  output logic          dc_store,
  output logic [AW-1:0] dc_addr,
  output logic [DW-1:0] dc_wdata,
  output logic          rc_hit,
  output logic [DW-1:0] rc_data
);
  logic [AW-1:0]  rc_tag [RCN];
  logic [DW-1:0]  rc_dat [RCN];
  logic [RCN-1:0] rc_v;
  logic [IW-1:0]  idx;
  logic           hit;
  logic           rc_wr;

  assign idx      = mreq_addr[IW+1:2];
  assign hit      = rc_v[idx] && (rc_tag[idx] == mreq_addr);
  assign dc_addr  = mreq_addr;
  assign dc_wdata = mreq_wdata;
  assign rc_data  = rc_dat[idx];

  always_comb begin
    dc_valid   = 1'b0;
    dc_store   = mreq_store;
    mreq_ready = 1'b0;
    rc_hit     = 1'b0;
    rc_wr      = 1'b0;
    unique case (mode)
      M_NORMAL: begin
        dc_valid   = mreq_valid;
        mreq_ready = dc_ready;
      end
      M_RUNAHEAD: begin
        dc_store = 1'b0;
        if (mreq_poison) begin
          mreq_ready = 1'b1;
        end else if (mreq_store) begin
          mreq_ready = 1'b1;
          rc_wr      = mreq_valid;
        end else if (hit) begin
          mreq_ready = 1'b1;
          rc_hit     = mreq_valid;
        end else begin
          dc_valid   = mreq_valid;
          mreq_ready = dc_ready;
        end
      end
      default: dc_store = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_v <= '0;
      for (int i = 0; i < RCN; i++) begin
        rc_tag[i] <= '0;
        rc_dat[i] <= '0;
      end
    end else if (do_restore) begin
      rc_v <= '0;
    end else if (rc_wr) begin
      rc_v[idx]   <= 1'b1;
      rc_tag[idx] <= mreq_addr;
      rc_dat[idx] <= mreq_wdata;
    end
  end
endmodule

// File: rtl/ra_controller.sv
module ra_controller
  import ra_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int PTW  = 6,
  parameter int RASW = 4,
  parameter int BHRW = 12,
  parameter int AW   = 32,
  parameter int IDW  = 4,
  parameter int PCW  = 32,
  parameter int RCN  = 4,
  localparam int RIW = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                head_valid,
  input  logic                head_is_load,
  input  logic                head_miss,
  input  logic [IDW-1:0]      head_id,
  input  logic [PCW-1:0]      head_pc,
  input  logic [RIW-1:0]      head_dst,
  input  logic                fill_valid,
  input  logic [IDW-1:0]      fill_id,
  input  logic [NREG*PTW-1:0] live_rmap,
  input  logic [RASW-1:0]     live_ras_ptr,
  input  logic [BHRW-1:0]     live_bhr,
  input  logic                wb_en,
  input  logic [RIW-1:0]      wb_idx,
  input  logic [DW-1:0]       wb_data,
  input  logic                wb_poison,
  input  logic [RIW-1:0]      rd_idx,
  output logic [DW-1:0]       rd_data,
  output logic                rd_poison,
  input  logic [RIW-1:0]      opa_idx,
  input  logic [RIW-1:0]      opb_idx,
  output logic                op_poison,
  input  logic                mreq_valid,
  output logic                mreq_ready,
  input  logic                mreq_store,
  input  logic                mreq_poison,
  input  logic [AW-1:0]       mreq_addr,
  input  logic [DW-1:0]       mreq_wdata,
  output logic                dc_valid,
  input  logic                dc_ready,
  output logic                dc_store,
  output logic [AW-1:0]       dc_addr,
  output logic [DW-1:0]       dc_wdata,
  output logic                rc_hit,
  output logic [DW-1:0]       rc_data,
  input  logic                br_valid,
  input  logic                br_poison,
  output logic                br_redirect_ok,
  output logic [1:0]          mode_o,
  output logic                flush,
  output logic                restore_valid,
  output logic [NREG*PTW-1:0] restore_rmap,
  output logic [RASW-1:0]     restore_ras_ptr,
  output logic [BHRW-1:0]     restore_bhr,
  output logic [PCW-1:0]      restart_pc
);
  ra_mode_e           mode;
  logic               enter;
  logic               do_restore;
  logic [NREG*DW-1:0] ck_data;

  ra_mode_fsm #(.IDW(IDW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .head_valid(head_valid), .head_is_load(head_is_load), .head_miss(head_miss),
    .head_id(head_id), .fill_valid(fill_valid), .fill_id(fill_id),
    .mode(mode), .enter(enter), .do_restore(do_restore)
  );

  ra_ckpt_store #(.NREG(NREG), .DW(DW), .PTW(PTW), .RASW(RASW), .BHRW(BHRW), .PCW(PCW)) u_ckpt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .enter(enter),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .live_rmap(live_rmap), .live_ras_ptr(live_ras_ptr), .live_bhr(live_bhr),
    .head_pc(head_pc), .ck_data(ck_data), .ck_rmap(restore_rmap),
    .ck_ras_ptr(restore_ras_ptr), .ck_bhr(restore_bhr), .ck_pc(restart_pc)
  );

  ra_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .mode(mode), .enter(enter), .enter_dst(head_dst),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .wb_poison(wb_poison),
    .do_restore(do_restore), .ck_data(ck_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_poison(rd_poison),
    .opa_idx(opa_idx), .opb_idx(opb_idx), .op_poison(op_poison)
  );

  ra_mem_gate #(.AW(AW), .DW(DW), .RCN(RCN)) u_mem (
    .clk(clk), .rst_n(rst_n), .mode(mode), .do_restore(do_restore),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_store(mreq_store),
    .mreq_poison(mreq_poison), .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
    .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_store(dc_store),
    .dc_addr(dc_addr), .dc_wdata(dc_wdata), .rc_hit(rc_hit), .rc_data(rc_data)
  );

  assign br_redirect_ok = br_valid && !(br_poison && (mode == M_RUNAHEAD));
  assign mode_o         = mode;
  assign flush          = do_restore;
  assign restore_valid  = do_restore;
endmodule

// File: rtl/ra_controller_chk.sv
module ra_controller_chk #(
  parameter int W_RMAP = 48,
  parameter int BHRW   = 12,
  parameter int PCW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_o,
  input logic              head_valid,
  input logic              head_is_load,
  input logic              head_miss,
  input logic              flush,
  input logic              mreq_ready,
  input logic              dc_valid,
  input logic              dc_store,
  input logic              br_valid,
  input logic              br_poison,
  input logic              br_redirect_ok,
  input logic [W_RMAP-1:0] restore_rmap,
  input logic [BHRW-1:0]   restore_bhr,
  input logic [PCW-1:0]    restart_pc
);
  p_stay_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !(head_valid && head_is_load && head_miss)) |=> (mode_o == 2'd0));

  p_ckpt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |=> ($stable(restore_rmap) && $stable(restore_bhr) && $stable(restart_pc)));

  p_restore_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |=> (mode_o == 2'd0));

  p_flush_after_runahead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> ($past(mode_o) == 2'd1));

  p_no_store_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |-> !(dc_valid && dc_store));

  p_poison_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && br_valid && br_poison) |-> !br_redirect_ok);

  p_restore_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (!mreq_ready && !dc_valid));
endmodule

bind ra_controller ra_controller_chk #(.W_RMAP(NREG*PTW), .BHRW(BHRW), .PCW(PCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o),
  .head_valid(head_valid), .head_is_load(head_is_load), .head_miss(head_miss),
  .flush(flush), .mreq_ready(mreq_ready), .dc_valid(dc_valid), .dc_store(dc_store),
  .br_valid(br_valid), .br_poison(br_poison), .br_redirect_ok(br_redirect_ok),
  .restore_rmap(restore_rmap), .restore_bhr(restore_bhr), .restart_pc(restart_pc)
);

// File: tb/ra_controller_tb_top.sv
`timescale 1ns/1ps
module ra_controller_tb_top;
  localparam int NREG = 8, DW = 32, PTW = 6, RASW = 4, BHRW = 12;
  localparam int AW = 32, IDW = 4, PCW = 32, RCN = 4, RIW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic head_valid, head_is_load, head_miss;
  logic [IDW-1:0] head_id, fill_id;
  logic [PCW-1:0] head_pc;
  logic [RIW-1:0] head_dst, wb_idx, rd_idx, opa_idx, opb_idx;
  logic fill_valid;
  logic [NREG*PTW-1:0] live_rmap, restore_rmap;
  logic [RASW-1:0] live_ras_ptr, restore_ras_ptr;
  logic [BHRW-1:0] live_bhr, restore_bhr;
  logic wb_en, wb_poison, rd_poison, op_poison;
  logic [DW-1:0] wb_data, rd_data, mreq_wdata, dc_wdata, rc_data;
  logic mreq_valid, mreq_ready, mreq_store, mreq_poison;
  logic [AW-1:0] mreq_addr, dc_addr;
  logic dc_valid, dc_ready, dc_store, rc_hit;
  logic br_valid, br_poison, br_redirect_ok;
  logic [1:0] mode_o;
  logic flush, restore_valid;
  logic [PCW-1:0] restart_pc;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [DW-1:0] exp_arch [NREG];
  bit            ep [NREG];
  bit            mv [RCN];
  logic [AW-1:0] mtag [RCN];
  logic [DW-1:0] mdat [RCN];

  always #4 clk = ~clk;

  ra_controller dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    head_valid = 0; head_is_load = 0; head_miss = 0; head_id = '0; head_pc = '0; head_dst = '0;
    fill_valid = 0; fill_id = '0;
    wb_en = 0; wb_idx = '0; wb_data = '0; wb_poison = 0;
    rd_idx = '0; opa_idx = '0; opb_idx = '0;
    mreq_valid = 0; mreq_store = 0; mreq_poison = 0; mreq_addr = '0; mreq_wdata = '0;
    dc_ready = 0; br_valid = 0; br_poison = 0;
  endtask

  function automatic logic [NREG*PTW-1:0] rand_rmap();
    return {$urandom, $urandom} & {(NREG*PTW){1'b1}};
  endfunction

  function automatic bit exp_poison(input logic [RIW-1:0] a, input logic [RIW-1:0] b);
    return ep[a] | ep[b];
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) begin
      rd_idx = RIW'(i);
      #0.1;
      check(rd_data == exp_arch[i], req, 64'(rd_data), 64'(exp_arch[i]));
      check(rd_poison == 1'b0, req, 64'(rd_poison), 64'd0);
    end
  endtask

  initial begin
    int unsigned seed_v;
    logic [NREG*PTW-1:0] s_rmap;
    logic [RASW-1:0] s_ras;
    logic [BHRW-1:0] s_bhr;
    logic [PCW-1:0] s_pc;
    logic [IDW-1:0] s_id;
    logic [RIW-1:0] s_dst;
    seed_v = $urandom(32'd20240611);
    idle();
    live_rmap = '0; live_ras_ptr = '0; live_bhr = '0;
    for (int i = 0; i < NREG; i++) begin exp_arch[i] = '0; ep[i] = 0; end
    for (int i = 0; i < RCN; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check(mode_o == 2'd0, "R1", 64'(mode_o), 64'd0);
    check(!flush && !restore_valid, "R1", 64'({flush, restore_valid}), 64'd0);
    check_regs("R1");
    step();

    for (int epi = 0; epi < 40; epi++) begin
      // normal phase
      for (int c = 0; c < 2 + int'($urandom % 5); c++) begin
        idle();
        live_rmap = rand_rmap(); live_ras_ptr = RASW'($urandom); live_bhr = BHRW'($urandom);
        wb_en = 1'($urandom); wb_idx = RIW'($urandom); wb_data = $urandom;
        wb_poison = 1'($urandom);
        head_valid = 1'($urandom); head_is_load = 1'($urandom);
        head_miss = !(head_valid && head_is_load);
        opa_idx = RIW'($urandom); opb_idx = RIW'($urandom);
        mreq_valid = 1'($urandom); mreq_store = 1'($urandom); dc_ready = 1'($urandom);
        mreq_addr = AW'($urandom); br_valid = 1; br_poison = 1'($urandom);
        #1;
        check(dc_valid == mreq_valid && mreq_ready == dc_ready && dc_store == mreq_store,
              "R10", 64'({dc_valid, mreq_ready, dc_store}), 64'({mreq_valid, dc_ready, mreq_store}));
        check(op_poison == 1'b0, "R7", 64'(op_poison), 64'd0);
        check(br_redirect_ok == 1'b1, "R9", 64'(br_redirect_ok), 64'd1);
        step();
        if (wb_en) exp_arch[wb_idx] = wb_data;
        check(mode_o == 2'd0, "R2", 64'(mode_o), 64'd0);
      end

      // entry cycle, with a commit in the same cycle
      idle();
      s_rmap = rand_rmap(); s_ras = RASW'($urandom); s_bhr = BHRW'($urandom);
      s_pc = $urandom; s_id = IDW'($urandom); s_dst = RIW'($urandom);
      live_rmap = s_rmap; live_ras_ptr = s_ras; live_bhr = s_bhr;
      head_valid = 1; head_is_load = 1; head_miss = 1;
      head_pc = s_pc; head_id = s_id; head_dst = s_dst;
      wb_en = 1; wb_idx = RIW'($urandom); wb_data = $urandom;
      step();
      exp_arch[wb_idx] = wb_data;
      check(mode_o == 2'd1, "R2", 64'(mode_o), 64'd1);
      for (int i = 0; i < NREG; i++) ep[i] = 0;
      ep[s_dst] = 1;
      idle();
      rd_idx = s_dst;
      #1;
      check(rd_poison == 1'b1, "R3", 64'(rd_poison), 64'd1);

      // runahead phase
      for (int c = 0; c < 3 + int'($urandom % 8); c++) begin
        logic [RIW-1:0] ri;
        idle();
        wb_en = 1'($urandom); wb_idx = RIW'($urandom); wb_data = $urandom;
        wb_poison = 1'($urandom);
        opa_idx = RIW'($urandom); opb_idx = RIW'($urandom);
        live_rmap = rand_rmap(); live_ras_ptr = RASW'($urandom); live_bhr = BHRW'($urandom);
        if ($urandom % 3 == 0) begin
          head_valid = 1; head_is_load = 1; head_miss = 1;
          head_id = IDW'($urandom); head_pc = $urandom; head_dst = RIW'($urandom);
        end
        if ($urandom % 4 == 0) begin fill_valid = 1; fill_id = s_id + 1'b1; end
        mreq_valid = 1; mreq_store = 1'($urandom); mreq_poison = ($urandom % 4 == 0);
        mreq_addr = AW'(($urandom % 8) << 2); mreq_wdata = $urandom; dc_ready = 1'($urandom);
        br_valid = 1; br_poison = 1'($urandom);
        ri = mreq_addr[3:2] == 2'd0 ? RIW'(0) : RIW'(mreq_addr[3:2]);
        #1;
        check(op_poison == exp_poison(opa_idx, opb_idx), "R7", 64'(op_poison),
              64'(exp_poison(opa_idx, opb_idx)));
        check(br_redirect_ok == !br_poison, "R9", 64'(br_redirect_ok), 64'(!br_poison));
        if (mreq_poison)
          check(mreq_ready && !dc_valid, "R9", 64'({mreq_ready, dc_valid}), 64'b10);
        else if (mreq_store)
          check(mreq_ready && !dc_valid, "R8", 64'({mreq_ready, dc_valid}), 64'b10);
        else if (mv[ri[1:0]] && mtag[ri[1:0]] == mreq_addr)
          check(rc_hit && rc_data == mdat[ri[1:0]] && !dc_valid && mreq_ready, "R8",
                64'(rc_data), 64'(mdat[ri[1:0]]));
        else
          check(dc_valid && !dc_store && !rc_hit && mreq_ready == dc_ready, "R10",
                64'({dc_valid, dc_store, rc_hit, mreq_ready}), 64'({3'b100, dc_ready}));
        step();
        if (wb_en) ep[wb_idx] = wb_poison;
        if (!mreq_poison && mreq_store) begin
          mv[ri[1:0]] = 1; mtag[ri[1:0]] = mreq_addr; mdat[ri[1:0]] = mreq_wdata;
        end
        check(mode_o == 2'd1, "R4", 64'(mode_o), 64'd1);
      end

      // matching fill
      idle();
      fill_valid = 1; fill_id = s_id;
      step();
      idle();
      mreq_valid = 1; dc_ready = 1;
      #1;
      check(mode_o == 2'd2 && flush && restore_valid, "R5",
            64'({mode_o, flush, restore_valid}), 64'({2'd2, 2'b11}));
      check(restart_pc == s_pc, "R5", 64'(restart_pc), 64'(s_pc));
      check(restore_rmap == s_rmap, "R3", 64'(restore_rmap), 64'(s_rmap));
      check(restore_ras_ptr == s_ras && restore_bhr == s_bhr, "R3",
            64'({restore_ras_ptr, restore_bhr}), 64'({s_ras, s_bhr}));
      check(!mreq_ready && !dc_valid, "R10", 64'({mreq_ready, dc_valid}), 64'd0);
      step();
      idle();
      for (int i = 0; i < RCN; i++) mv[i] = 0;
      for (int i = 0; i < NREG; i++) ep[i] = 0;
      check(mode_o == 2'd0 && !flush, "R5", 64'({mode_o, flush}), 64'd0);
      check_regs("R6");
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule